// File: doc/BRIEF.md
# Waveform-Indexed Timing Edge Scheduler

This block turns a stream of per-vector pattern symbols into timed edge requests for one tester channel. A table of 256 waveform entries, each with four event slots, is addressed by an 8-bit symbol. Each slot holds an enable, a 3-bit action code (drive high/low/off, compare high/low/off and similar), a 2-bit coarse period count and an 8-bit fine code. The fine code counts 1/256 steps of the 10 ns reference period. One vector period equals one reference clock cycle. On every cycle with the vector strobe raised, the selected entry's enabled events are scheduled. A shared 8-bit offset, in fine steps, is added to every event delay.

Scheduled events wait in a four-slot ring indexed by the cycle number modulo four. Events from up to four consecutive vectors can therefore be pending at the same time. Every cycle the slot that has come due is presented on sixteen output lanes. The lanes are packed from lane 0 and sorted by fine code, so that a downstream vernier can place each edge inside that cycle. A delay pushed past the four-period span by the offset is clamped to the last fine step of the fourth period, and a sticky flag records the event.

Top module: `wf_edge_sched`

## Requirements
- R1: A table write (`wr_en` high at a rising edge) stores enable, action, coarse and fine for event `wr_evt` of entry `wr_sym`. A vector strobed at that same edge still uses the previous contents, and vectors strobed at later edges use the new contents.
- R2: An enabled event of a vector strobed at rising edge k, with effective coarse count c, appears on the output lanes exactly once. It appears in the cycle that follows rising edge k+1+c.
- R3: The effective delay is coarse*256 + fine + `glb_off`. Its upper bits give the effective coarse count and its low 8 bits give the fine code that is emitted.
- R4: If the effective delay exceeds 1023, the event is emitted with coarse 3 and fine 255, and `range_err` rises after that edge and stays high until reset.
- R5: Disabled events are never emitted and never set `range_err`, whatever their stored delay.
- R6: Events from strobes on up to four consecutive edges are all held and all emitted, including events from different vectors that fall due in the same cycle.
- R7: The events due in a cycle occupy lanes 0..n-1 with no gaps, in ascending fine code. Equal fine codes are ordered older vector first, then lower event index.
- R8: Each valid lane carries its event's 3-bit action code in `ev_act[3*i +: 3]` and its fine code in `ev_fine[8*i +: 8]`.
- R9: While `rst` is high at a rising edge, no lane is valid after that edge. Reset clears `range_err` and discards every pending event, and the table contents are kept.
- R10: A cycle with `vec_stb` low schedules nothing, and events that are already pending still fall due on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one vector period per cycle |
| rst | input | 1 | Synchronous reset, active high |
| vec_stb | input | 1 | A vector starts in this cycle |
| vec_sym | input | 8 | Pattern symbol selecting the waveform entry |
| glb_off | input | 8 | Global delay offset in fine steps |
| wr_en | input | 1 | Table write strobe |
| wr_sym | input | 8 | Entry being written |
| wr_evt | input | 2 | Event slot being written |
| wr_ena | input | 1 | Event enable to store |
| wr_act | input | 3 | Action code to store |
| wr_crs | input | 2 | Coarse period count to store |
| wr_fine | input | 8 | Fine code to store |
| ev_valid | output | 16 | Lane valid bits for the current cycle |
| ev_act | output | 48 | Action code per lane |
| ev_fine | output | 128 | Fine code per lane |
| range_err | output | 1 | Sticky flag for a clamped delay |

## Verification
The assertions check several properties on every cycle. The valid lanes stay packed from lane 0, and their fine codes never decrease. The number of events leaving equals the number drained from the due ring slot. The offset never shortens a delay, the range flag never drops outside reset, and nothing leaves while reset is held. Only the bench's scenarios can show that each event arrives in the right cycle with the right fine code and action after an offset carry or a clamp. The same applies to the tie order across overlapping vectors, to a write in the same cycle as a strobe using the old entry, and to pending work vanishing at reset. The bench covers these with a reference model driven over every table entry and several hundred mixed vectors.

// File: rtl/wf_edge_sched_pkg.sv
package wf_edge_sched_pkg;
  // Action codes carried through unchanged to the pin electronics.
  typedef enum logic [2:0] {
    ACT_DRIVE_LO  = 3'd0,
    ACT_DRIVE_HI  = 3'd1,
    ACT_DRIVE_OFF = 3'd2,
    ACT_CMP_LO    = 3'd3,
    ACT_CMP_HI    = 3'd4,
    ACT_CMP_OFF   = 3'd5,
    ACT_CMP_MID   = 3'd6,
    ACT_NONE      = 3'd7
  } act_e;
endpackage

// File: rtl/wf_table.sv
module wf_table #(
  parameter int SYM_W = 8,
  parameter int NEV   = 4,
  parameter int ENT_W = 14,
  localparam int DEPTH = 1 << SYM_W,
  localparam int EV_W  = $clog2(NEV)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [SYM_W-1:0]     wr_sym,
  input  logic [EV_W-1:0]      wr_evt,
  input  logic [ENT_W-1:0]     wr_data,
  input  logic [SYM_W-1:0]     rd_sym,
  output logic [NEV*ENT_W-1:0] rd_data
);
  logic [ENT_W-1:0] mem [DEPTH][NEV];

  // Writes land at the edge, so a read in the same cycle sees old data.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_sym][wr_evt] <= wr_data;
  end

  for (genvar e = 0; e < NEV; e++) begin : g_rd
    assign rd_data[e*ENT_W +: ENT_W] = mem[rd_sym][e];
  end
endmodule

// File: rtl/edge_calc.sv
module edge_calc #(
  parameter int CRS_W  = 2,
  parameter int FINE_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic [CRS_W-1:0]  crs,
  input  logic [FINE_W-1:0] fine,
  input  logic [OFF_W-1:0]  off,
  output logic [CRS_W-1:0]  crs_o,
  output logic [FINE_W-1:0] fine_o,
  output logic              ovf
);
  localparam int TOT_W = CRS_W + FINE_W;

  // Returns {overflow, clamped delay}; offset is in fine steps.
  function automatic logic [TOT_W:0] shift_delay(
    input logic [TOT_W-1:0] base, input logic [OFF_W-1:0] add);
    logic [TOT_W:0] sum;
    sum = {1'b0, base} + (TOT_W+1)'(add);
    if (sum[TOT_W]) return {1'b1, {TOT_W{1'b1}}};
    return sum;
  endfunction

  logic [TOT_W:0] res;
  assign res    = shift_delay({crs, fine}, off);
  assign ovf    = res[TOT_W];
  assign crs_o  = res[TOT_W-1:FINE_W];
  assign fine_o = res[FINE_W-1:0];
endmodule

// File: rtl/edge_sorter.sv
module edge_sorter #(
  parameter int N      = 16,
  parameter int FINE_W = 8,
  parameter int ACT_W  = 3,
  localparam int IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]        in_valid,
  input  logic [N*FINE_W-1:0] in_fine,
  input  logic [N*ACT_W-1:0]  in_act,
  output logic [N-1:0]        out_valid,
  output logic [N*FINE_W-1:0] out_fine,
  output logic [N*ACT_W-1:0]  out_act
);
  logic [IDX_W-1:0] rank [N];

  // Rank = number of valid items that sort ahead (lower fine, or equal fine at lower position).
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (in_valid[j] &&
            ((in_fine[j*FINE_W +: FINE_W] < in_fine[i*FINE_W +: FINE_W]) ||
             ((in_fine[j*FINE_W +: FINE_W] == in_fine[i*FINE_W +: FINE_W]) && (j < i))))
          rank[i] = rank[i] + IDX_W'(1);
      end
    end
  end

  always_comb begin
    out_valid = '0;
    out_fine  = '0;
    out_act   = '0;
    for (int r = 0; r < N; r++) begin
      for (int i = 0; i < N; i++) begin
        if (in_valid[i] && (rank[i] == IDX_W'(r))) begin
          out_valid[r]                  = 1'b1;
          out_fine[r*FINE_W +: FINE_W]  = out_fine[r*FINE_W +: FINE_W] | in_fine[i*FINE_W +: FINE_W];
          out_act[r*ACT_W +: ACT_W]     = out_act[r*ACT_W +: ACT_W] | in_act[i*ACT_W +: ACT_W];
        end
      end
    end
  end
endmodule

// File: rtl/wf_edge_sched.sv
module wf_edge_sched #(
  parameter int SYM_W  = 8,
  parameter int NEV    = 4,
  parameter int SPAN   = 4,
  parameter int FINE_W = 8,
  parameter int ACT_W  = 3,
  parameter int OFF_W  = 8,
  localparam int EV_W  = $clog2(NEV),
  localparam int CRS_W = $clog2(SPAN),
  localparam int NLANE = NEV * SPAN
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vec_stb,
  input  logic [SYM_W-1:0]        vec_sym,
  input  logic [OFF_W-1:0]        glb_off,
  input  logic                    wr_en,
  input  logic [SYM_W-1:0]        wr_sym,
  input  logic [EV_W-1:0]         wr_evt,
  input  logic                    wr_ena,
  input  logic [ACT_W-1:0]        wr_act,
  input  logic [CRS_W-1:0]        wr_crs,
  input  logic [FINE_W-1:0]       wr_fine,
  output logic [NLANE-1:0]        ev_valid,
  output logic [NLANE*ACT_W-1:0]  ev_act,
  output logic [NLANE*FINE_W-1:0] ev_fine,
  output logic                    range_err
);
  // Entry layout per event: {enable, action, coarse, fine}. SPAN and NEV are powers of two.
  localparam int ENT_W = 1 + ACT_W + CRS_W + FINE_W;
  localparam int POS_W = CRS_W + EV_W;

  logic [NEV*ENT_W-1:0] rd_data;

  wf_table #(.SYM_W(SYM_W), .NEV(NEV), .ENT_W(ENT_W)) u_table (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_sym  (wr_sym),
    .wr_evt  (wr_evt),
    .wr_data ({wr_ena, wr_act, wr_crs, wr_fine}),
    .rd_sym  (vec_sym),
    .rd_data (rd_data)
  );

  // Named per-event wires, shared by the scheduling logic and the assertions.
  logic [NEV-1:0]    ev_en, ev_ovf, ev_new;
  logic [ACT_W-1:0]  raw_act  [NEV];
  logic [CRS_W-1:0]  raw_crs  [NEV];
  logic [FINE_W-1:0] raw_fine [NEV];
  logic [CRS_W-1:0]  eff_crs  [NEV];
  logic [FINE_W-1:0] eff_fine [NEV];
  logic [CRS_W-1:0]  tgt_slot [NEV];
  logic [POS_W-1:0]  tgt_pos  [NEV];
  logic [CRS_W-1:0]  ptr;

  for (genvar e = 0; e < NEV; e++) begin : g_ev
    assign {ev_en[e], raw_act[e], raw_crs[e], raw_fine[e]} = rd_data[e*ENT_W +: ENT_W];

    edge_calc #(.CRS_W(CRS_W), .FINE_W(FINE_W), .OFF_W(OFF_W)) u_calc (
      .crs    (raw_crs[e]),
      .fine   (raw_fine[e]),
      .off    (glb_off),
      .crs_o  (eff_crs[e]),
      .fine_o (eff_fine[e]),
      .ovf    (ev_ovf[e])
    );

    assign ev_new[e]   = vec_stb && ev_en[e];
    assign tgt_slot[e] = ptr + CRS_W'(1) + eff_crs[e];
    // Older vectors (larger coarse) take lower positions: the tie order.
    assign tgt_pos[e]  = {CRS_W'(SPAN - 1) - eff_crs[e], EV_W'(e)};

    // R4: the offset can only push an edge later, never earlier.
    a_r4_offset_monotone: assert property (@(posedge clk) disable iff (rst)
      ev_new[e] |-> ({eff_crs[e], eff_fine[e]} >= {raw_crs[e], raw_fine[e]}));
  end

  // Pending-event ring, one slot per reference cycle modulo SPAN.
  logic [NLANE-1:0]        ring_v [SPAN];
  logic [NLANE*FINE_W-1:0] ring_f [SPAN];
  logic [NLANE*ACT_W-1:0]  ring_a [SPAN];
  logic [NLANE-1:0]        due_v;
  logic [NLANE*FINE_W-1:0] due_f;
  logic [NLANE*ACT_W-1:0]  due_a;
  logic [NLANE-1:0]        srt_v;
  logic [NLANE*FINE_W-1:0] srt_f;
  logic [NLANE*ACT_W-1:0]  srt_a;
  logic                    clamp_hit;

  assign due_v     = ring_v[ptr];
  assign due_f     = ring_f[ptr];
  assign due_a     = ring_a[ptr];
  assign clamp_hit = |(ev_new & ev_ovf);

  edge_sorter #(.N(NLANE), .FINE_W(FINE_W), .ACT_W(ACT_W)) u_sort (
    .in_valid  (due_v),
    .in_fine   (due_f),
    .in_act    (due_a),
    .out_valid (srt_v),
    .out_fine  (srt_f),
    .out_act   (srt_a)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SPAN; s++) ring_v[s] <= '0;
      ptr       <= '0;
      ev_valid  <= '0;
      ev_fine   <= '0;
      ev_act    <= '0;
      range_err <= 1'b0;
    end else begin
      ptr      <= ptr + CRS_W'(1);
      ev_valid <= srt_v;
      ev_fine  <= srt_f;
      ev_act   <= srt_a;
      // Drain the due slot; a new event landing in the same slot overrides the clear.
      ring_v[ptr] <= '0;
      for (int e = 0; e < NEV; e++) begin
        if (ev_new[e]) begin
          ring_v[tgt_slot[e]][tgt_pos[e]]                  <= 1'b1;
          ring_f[tgt_slot[e]][tgt_pos[e]*FINE_W +: FINE_W] <= eff_fine[e];
          ring_a[tgt_slot[e]][tgt_pos[e]*ACT_W +: ACT_W]   <= raw_act[e];
        end
      end
      if (clamp_hit) range_err <= 1'b1;
    end
  end

  // R9: nothing leaves while reset is held.
  a_r9_quiet_in_reset: assert property (@(posedge clk)
    rst |=> (ev_valid == '0));

  // R4: the range flag is sticky.
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    range_err |=> range_err);

  // R7: valid lanes are packed from lane 0.
  a_r7_lanes_packed: assert property (@(posedge clk) disable iff (rst)
    ((ev_valid + NLANE'(1)) & ev_valid) == '0);

  // R6: every event drained from the due slot leaves on a lane.
  a_r6_count_kept: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones(ev_valid) == $past($countones(due_v))));

  for (genvar r = 1; r < NLANE; r++) begin : g_ord
    // R7: fine codes never decrease across valid lanes.
    a_r7_fine_ascending: assert property (@(posedge clk) disable iff (rst)
      ev_valid[r] |-> (ev_fine[r*FINE_W +: FINE_W] >= ev_fine[(r-1)*FINE_W +: FINE_W]));
  end
endmodule

// File: tb/tb_wf_edge_sched.sv
module tb_wf_edge_sched;
  import wf_edge_sched_pkg::*;

  localparam int NL = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, vec_stb = 1'b0, wr_en = 1'b0, wr_ena = 1'b0;
  logic [7:0]  vec_sym = '0, glb_off = '0, wr_sym = '0, wr_fine = '0;
  logic [1:0]  wr_evt = '0, wr_crs = '0;
  logic [2:0]  wr_act = '0;
  logic [15:0] ev_valid;
  logic [47:0] ev_act;
  logic [127:0] ev_fine;
  logic        range_err;

  wf_edge_sched dut (
    .clk(clk), .rst(rst), .vec_stb(vec_stb), .vec_sym(vec_sym), .glb_off(glb_off),
    .wr_en(wr_en), .wr_sym(wr_sym), .wr_evt(wr_evt), .wr_ena(wr_ena), .wr_act(wr_act),
    .wr_crs(wr_crs), .wr_fine(wr_fine), .ev_valid(ev_valid), .ev_act(ev_act),
    .ev_fine(ev_fine), .range_err(range_err)
  );

  int checks = 0, errors = 0, e_next = 0;
  bit done = 0, exp_err = 0;

  // Mirror of the table, kept from the bench's own writes.
  bit m_en [256][4];
  int m_act [256][4], m_crs [256][4], m_fine [256][4];

  // Expected events: due edge, tie key, fine, action.
  int it_due [128], it_key [128], it_fine [128], it_act [128];
  bit it_live [128];

  task automatic add_item(int due, int key, int fine, int act);
    for (int k = 0; k < 128; k++) begin
      if (!it_live[k]) begin
        it_live[k] = 1; it_due[k] = due; it_key[k] = key; it_fine[k] = fine; it_act[k] = act;
        return;
      end
    end
  endtask

  task automatic schedule(int sym, int off, int edge_n);
    for (int e = 0; e < 4; e++) begin
      if (m_en[sym][e]) begin
        int tot;
        tot = m_crs[sym][e] * 256 + m_fine[sym][e] + off;
        if (tot > 1023) begin tot = 1023; exp_err = 1; end
        add_item(edge_n + 1 + tot / 256, edge_n * 4 + e, tot % 256, m_act[sym][e]);
      end
    end
  endtask

  task automatic check(int m, string req);
    int idx [16];
    int n = 0;
    bit bad = 0;
    for (int k = 0; k < 128; k++) begin
      if (it_live[k] && it_due[k] == m) begin
        if (n < 16) idx[n] = k;
        n++;
        it_live[k] = 0;
      end
    end
    for (int a = 1; a < n; a++) begin
      for (int b = a; b > 0; b--) begin
        int p, q;
        p = idx[b-1]; q = idx[b];
        if (it_fine[q] < it_fine[p] || (it_fine[q] == it_fine[p] && it_key[q] < it_key[p])) begin
          idx[b-1] = q; idx[b] = p;
        end
      end
    end
    for (int r = 0; r < NL; r++) begin
      bit ev;
      int ef, ea;
      ev = (r < n);
      ef = ev ? it_fine[idx[r]] : 0;
      ea = ev ? it_act[idx[r]] : 0;
      if (ev_valid[r] !== ev || (ev && (int'(ev_fine[r*8 +: 8]) != ef || int'(ev_act[r*3 +: 3]) != ea))) begin
        $display("FAIL %s edge %0d lane %0d: got v=%0b fine=%0d act=%0d exp v=%0b fine=%0d act=%0d",
                 req, m, r, ev_valid[r], ev_fine[r*8 +: 8], ev_act[r*3 +: 3], ev, ef, ea);
        bad = 1;
      end
    end
    checks++;
    if (bad) errors++;
    checks++;
    if (range_err !== exp_err) begin
      $display("FAIL %s edge %0d range_err: got %0b exp %0b", req, m, range_err, exp_err);
      errors++;
    end
  endtask

  // Apply the inputs already set for one rising edge, then check after it.
  task automatic tick(string req);
    if (rst) begin
      for (int k = 0; k < 128; k++) it_live[k] = 0;
      exp_err = 0;
    end else if (vec_stb) begin
      schedule(int'(vec_sym), int'(glb_off), e_next);
    end
    if (wr_en) begin
      m_en[wr_sym][wr_evt] = wr_ena; m_act[wr_sym][wr_evt] = int'(wr_act);
      m_crs[wr_sym][wr_evt] = int'(wr_crs); m_fine[wr_sym][wr_evt] = int'(wr_fine);
    end
    @(posedge clk);
    e_next++;
    @(negedge clk);
    check(e_next - 1, req);
    vec_stb = 0;
    wr_en = 0;
  endtask

  task automatic put_wr(int sym, int evt, bit en, int act, int crs, int fine);
    wr_en = 1; wr_sym = 8'(sym); wr_evt = 2'(evt); wr_ena = en;
    wr_act = 3'(act); wr_crs = 2'(crs); wr_fine = 8'(fine);
  endtask

  task automatic wr(int sym, int evt, bit en, int act, int crs, int fine);
    put_wr(sym, evt, en, act, crs, fine);
    tick("R1");
  endtask

  task automatic put_vec(int sym, int off);
    vec_stb = 1; vec_sym = 8'(sym); glb_off = 8'(off);
  endtask

  task automatic vec(int sym, int off, string req);
    put_vec(sym, off);
    tick(req);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R9: reset state.
    idle(2, "R9");
    rst = 0;

    // Fill every entry with varied content (quiet output checks R10 along the way).
    for (int s = 0; s < 256; s++)
      for (int e = 0; e < 4; e++)
        wr(s, e, ((s * 7 + e) % 5) != 0, (s + e) % 8, (s >> e) % 4, (s * 37 + e * 91) % 256);

    // R2: each coarse count lands in its own cycle.
    for (int c = 0; c < 4; c++) begin
      wr(12, 0, 1, int'(ACT_DRIVE_HI), c, 100);
      for (int e = 1; e < 4; e++) wr(12, e, 0, 0, 0, 0);
      vec(12, 0, "R2");
      idle(5, "R2");
    end

    // R3: offset carries from fine into coarse (1*256+200+100 = 556).
    wr(12, 0, 1, int'(ACT_CMP_LO), 1, 200);
    vec(12, 100, "R3");
    idle(5, "R3");

    // R5: disabled events with delays that would overflow.
    for (int e = 0; e < 4; e++) wr(13, e, 0, 1, 3, 255);
    vec(13, 255, "R5");
    idle(5, "R5");

    // R4: clamp to the last fine step and set the sticky flag.
    wr(14, 0, 1, int'(ACT_CMP_HI), 3, 250);
    for (int e = 1; e < 4; e++) wr(14, e, 0, 0, 0, 0);
    vec(14, 10, "R4");
    idle(6, "R4");

    // R1: a write in the same cycle as the strobe leaves that vector on old content.
    wr(15, 0, 1, 1, 0, 1);
    for (int e = 1; e < 4; e++) wr(15, e, 0, 0, 0, 0);
    put_wr(15, 0, 1, 2, 0, 2);
    put_vec(15, 0);
    tick("R1");
    idle(2, "R1");
    vec(15, 0, "R1");
    idle(2, "R1");

    // R6, R7: four vectors in a row, equal fine codes across coarse counts.
    for (int e = 0; e < 4; e++) wr(20, e, 1, e + 4, 3 - e, 50);
    for (int i = 0; i < 4; i++) vec(20, 0, "R6,R7");
    idle(6, "R6,R7");

    // R8: action and fine codes per lane over a mixed stream with gaps (R10).
    for (int i = 0; i < 600; i++) begin
      if (i % 7 == 6) tick("R10");
      else vec((i * 53 + 11) % 256, (i * 29) % 256, "R8,R7,R6,R3");
    end
    idle(5, "R8");

    // R9: reset discards pending events and clears the flag.
    for (int i = 0; i < 3; i++) vec(20, 0, "R6");
    rst = 1;
    idle(2, "R9");
    rst = 0;
    idle(6, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule